// File: doc/BRIEF.md
# Predicated Vector Scatter-Store Sequencer

This block takes a single vector store command and breaks it into a sequence of 32-bit memory writes, one for each active lane. A command carries a 64-bit base, a vector of per-lane index values, a vector of data elements and a predicate that has one bit per data byte. For each active lane, taken in ascending lane order, the block forms an address from the base plus the lane's index. The index is first extended to 64 bits and then scaled. The block stores the low word of that lane's data element through a valid/ready write port.

Each command has its own configuration, set by four flags:

- lane width (32 or 64 bits);
- index width (32 or 64 bits);
- extension of a 32-bit index (signed or unsigned);
- scale (multiply by 1 or by 4).

When the base register number is 31, the block takes the base from the stack pointer and checks that it is 16-byte aligned. A misaligned stack pointer raises a fault, and no write is made. When no lane is active, a configuration input decides whether that check still runs. The end of every command is marked by a one-cycle done pulse.

Top module: `scatter_store_seq`

## Requirements
- R1: `cmd_ready` is high after reset and whenever the block is idle. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` stays low while the block is working on that command.
- R2: The lane width sets the lane count: 32-bit lanes give VLEN/32 lanes and 64-bit lanes give VLEN/64 lanes. A lane is active only if the predicate bit at its lowest byte is set: bit 4*e for 32-bit lanes and bit 8*e for 64-bit lanes. Every other predicate bit is ignored, and an inactive lane produces no write.
- R3: Writes are issued in strictly ascending lane order, with exactly one write for each active lane.
- R4: The write data is bits [31:0] of the lane's data element, for both lane widths.
- R5: With a 32-bit index, bits [31:0] of the index element are sign-extended when `cmd_idx_unsigned` is 0 and zero-extended when it is 1. With 64-bit lanes, the upper half of the index element is ignored.
- R6: With a 64-bit index (`cmd_idx64`=1, which requires 64-bit lanes), the whole index element is used as an unsigned value.
- R7: The write address is base + (extended index << 2) when `cmd_scale4` is 1 and base + extended index otherwise. The sum wraps modulo 2^64.
- R8: The base is `cmd_sp` when `cmd_base_reg` is 31. Otherwise it is `cmd_gpr`.
- R9: If the base is the stack pointer, at least one lane is active and `cmd_sp[3:0]` is not zero, the block raises `align_fault` together with `done` and issues no writes. A general-register base is never checked.
- R10: If no lane is active, a misaligned stack-pointer base raises the fault only when `cfg_check_empty` is 1. Otherwise the command ends with `done` and no fault.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold their values.
- R12: `done` is a one-cycle pulse. It comes in the cycle after the last write is accepted, or two cycles after the command is taken when no write is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_base_reg | input | 5 | Base register number; 31 selects the stack pointer |
| cmd_gpr | input | 64 | General-register base value |
| cmd_sp | input | 64 | Stack-pointer base value |
| cmd_idx | input | VLEN | Index vector |
| cmd_data | input | VLEN | Data vector |
| cmd_pred | input | VLEN/8 | Byte predicate |
| cmd_lane64 | input | 1 | 1: 64-bit lanes, 0: 32-bit lanes |
| cmd_idx64 | input | 1 | 1: 64-bit index, 0: 32-bit index |
| cmd_idx_unsigned | input | 1 | Zero-extend a 32-bit index when 1 |
| cmd_scale4 | input | 1 | Shift the index left by 2 when 1 |
| cfg_check_empty | input | 1 | Run the stack-pointer check when no lane is active |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 64 | Write byte address |
| mem_wdata | output | 32 | Write data word |
| done | output | 1 | Command finished (pulse) |
| align_fault | output | 1 | Stack-pointer misalignment, given with done |

## Verification
The assertions check the port protocol on every cycle:

- the write request holds steady while it is stalled;
- `done` lasts a single cycle;
- a fault comes only together with `done` and never during a write;
- `cmd_ready` and `mem_valid` are never high together;
- lanes strictly ascend from one accepted write to the next;
- every issued lane is active.

Only the bench scenarios can show the numeric results. These are the sign or zero extension of the index, the scaling and the wrap of the address sum, and the choice of the low word. They also cover which predicate bits are ignored, the choice between stack pointer and general register, and the effect of `cfg_check_empty` when the mask is empty.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_SEND = 2'd2
  } sst_state_e;

  typedef struct packed {
    logic lane64;
    logic idx64;
    logic idx_unsigned;
    logic scale4;
  } sst_cfg_t;

endpackage

// File: rtl/sst_lane_pick.sv
// Finds the lowest active lane whose number is at or above a start point.
module sst_lane_pick #(
  parameter int LANES = 8,
  parameter int IW    = $clog2(LANES)
) (
  input  logic [LANES-1:0] active,
  input  logic [IW:0]      start,
  output logic             hit,
  output logic [IW-1:0]    lane
);

  always_comb begin
    hit  = 1'b0;
    lane = '0;
    for (int e = LANES - 1; e >= 0; e--) begin
      if (active[e] && ((IW+1)'(e) >= start)) begin
        hit  = 1'b1;
        lane = IW'(e);
      end
    end
  end

endmodule

// File: rtl/sst_lane_addr.sv
// Picks one lane's index and data, extends and scales the index, adds the base.
module sst_lane_addr
  import sst_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int LANES = VLEN / 32,
  parameter int IW    = $clog2(LANES)
) (
  input  logic [63:0]     base,
  input  logic [VLEN-1:0] idx_vec,
  input  logic [VLEN-1:0] data_vec,
  input  logic [IW-1:0]   lane,
  input  sst_cfg_t        cfg,
  output logic [63:0]     addr,
  output logic [31:0]     word
);

  localparam int WORDS = VLEN / 32;

  logic [WORDS-1:0][31:0] idx_w;
  logic [WORDS-1:0][31:0] dat_w;
  logic [IW-1:0]          lo_sel;
  logic [IW-1:0]          hi_sel;
  logic [63:0]            elem;
  logic [63:0]            ext;

  assign idx_w = idx_vec;
  assign dat_w = data_vec;

  // a 64-bit lane spans two words: its low word is at an even index
  always_comb begin
    if (cfg.lane64) begin
      lo_sel = {lane[IW-2:0], 1'b0};
      hi_sel = {lane[IW-2:0], 1'b1};
    end else begin
      lo_sel = lane;
      hi_sel = lane;
    end
  end

  always_comb begin
    elem = cfg.lane64 ? {idx_w[hi_sel], idx_w[lo_sel]} : {32'd0, idx_w[lo_sel]};
    if (cfg.idx64)
      ext = elem;
    else if (cfg.idx_unsigned)
      ext = {32'd0, elem[31:0]};
    else
      ext = {{32{elem[31]}}, elem[31:0]};
    addr = base + (cfg.scale4 ? (ext << 2) : ext);
    word = dat_w[lo_sel];
  end

endmodule

// File: rtl/scatter_store_seq.sv
module scatter_store_seq
  import sst_pkg::*;
#(
  parameter int VLEN     = 256,
  parameter int SP_ALIGN = 16,
  parameter int SP_REG   = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [4:0]        cmd_base_reg,
  input  logic [63:0]       cmd_gpr,
  input  logic [63:0]       cmd_sp,
  input  logic [VLEN-1:0]   cmd_idx,
  input  logic [VLEN-1:0]   cmd_data,
  input  logic [VLEN/8-1:0] cmd_pred,
  input  logic              cmd_lane64,
  input  logic              cmd_idx64,
  input  logic              cmd_idx_unsigned,
  input  logic              cmd_scale4,
  input  logic              cfg_check_empty,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [63:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              done,
  output logic              align_fault
);

  localparam int LANES = VLEN / 32;
  localparam int IW    = $clog2(LANES);
  localparam int AL    = $clog2(SP_ALIGN);

  sst_state_e      state_q;
  sst_cfg_t        cfg_q;
  logic [63:0]     base_q;
  logic            is_sp_q;
  logic            chk_empty_q;
  logic [VLEN-1:0] idx_q;
  logic [VLEN-1:0] data_q;
  logic [LANES-1:0] act_q;
  logic [IW-1:0]   cur_q;

  logic [LANES-1:0] act32;
  logic [LANES-1:0] act64;
  logic [IW:0]      pick_start;
  logic             pick_hit;
  logic [IW-1:0]    pick_lane;
  logic [63:0]      lane_addr;
  logic [31:0]      lane_word;
  logic             misaligned;
  logic             fault_now;
  logic             unused_pred;
  sst_cfg_t         cmd_cfg;

  // only the predicate bit at each lane's lowest byte matters
  assign unused_pred = ^cmd_pred;

  for (genvar e = 0; e < LANES; e++) begin : g_act
    assign act32[e] = cmd_pred[e*4];
    if (e < LANES / 2) begin : g_wide
      assign act64[e] = cmd_pred[e*8];
    end else begin : g_none
      assign act64[e] = 1'b0;
    end
  end

  assign cmd_cfg = '{lane64: cmd_lane64, idx64: cmd_idx64,
                     idx_unsigned: cmd_idx_unsigned, scale4: cmd_scale4};

  assign pick_start = (state_q == ST_EVAL) ? '0 : ((IW+1)'(cur_q) + 1'b1);

  sst_lane_pick #(.LANES(LANES), .IW(IW)) u_pick (
    .active (act_q),
    .start  (pick_start),
    .hit    (pick_hit),
    .lane   (pick_lane)
  );

  sst_lane_addr #(.VLEN(VLEN), .LANES(LANES), .IW(IW)) u_addr (
    .base     (base_q),
    .idx_vec  (idx_q),
    .data_vec (data_q),
    .lane     (pick_lane),
    .cfg      (cfg_q),
    .addr     (lane_addr),
    .word     (lane_word)
  );

  assign misaligned = |base_q[AL-1:0];
  assign fault_now  = is_sp_q && misaligned && (pick_hit || chk_empty_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cmd_ready   <= 1'b1;
      mem_valid   <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      done        <= 1'b0;
      align_fault <= 1'b0;
      cfg_q       <= '0;
      base_q      <= '0;
      is_sp_q     <= 1'b0;
      chk_empty_q <= 1'b0;
      idx_q       <= '0;
      data_q      <= '0;
      act_q       <= '0;
      cur_q       <= '0;
    end else begin
      done        <= 1'b0;
      align_fault <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            cmd_ready   <= 1'b0;
            state_q     <= ST_EVAL;
            cfg_q       <= cmd_cfg;
            is_sp_q     <= (cmd_base_reg == 5'(SP_REG));
            base_q      <= (cmd_base_reg == 5'(SP_REG)) ? cmd_sp : cmd_gpr;
            chk_empty_q <= cfg_check_empty;
            idx_q       <= cmd_idx;
            data_q      <= cmd_data;
            act_q       <= cmd_lane64 ? act64 : act32;
          end
        end
        ST_EVAL: begin
          if (fault_now || !pick_hit) begin
            done        <= 1'b1;
            align_fault <= fault_now;
            cmd_ready   <= 1'b1;
            state_q     <= ST_IDLE;
          end else begin
            mem_valid <= 1'b1;
            mem_addr  <= lane_addr;
            mem_wdata <= lane_word;
            cur_q     <= pick_lane;
            state_q   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (mem_ready) begin
            if (pick_hit) begin
              mem_addr  <= lane_addr;
              mem_wdata <= lane_word;
              cur_q     <= pick_lane;
            end else begin
              mem_valid <= 1'b0;
              done      <= 1'b1;
              cmd_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !mem_valid); // R1
  AST_ACTIVE_LANE: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> act_q[cur_q]); // R2
  AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |=> (!mem_valid || (cur_q > $past(cur_q)))); // R3
  AST_FAULT_DONE: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (done && !mem_valid)); // R9
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12

endmodule

// File: tb/scatter_store_seq_test.sv
module scatter_store_seq_test;

  localparam int VLEN = 256;
  localparam int PB   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [4:0]      cmd_base_reg = '0;
  logic [63:0]     cmd_gpr = '0;
  logic [63:0]     cmd_sp = '0;
  logic [VLEN-1:0] cmd_idx = '0;
  logic [VLEN-1:0] cmd_data = '0;
  logic [PB-1:0]   cmd_pred = '0;
  logic            cmd_lane64 = 1'b0;
  logic            cmd_idx64 = 1'b0;
  logic            cmd_idx_unsigned = 1'b0;
  logic            cmd_scale4 = 1'b0;
  logic            cfg_check_empty = 1'b0;
  logic            mem_valid;
  logic            mem_ready = 1'b0;
  logic [63:0]     mem_addr;
  logic [31:0]     mem_wdata;
  logic            done;
  logic            align_fault;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [63:0] exp_a [0:7];
  logic [31:0] exp_d [0:7];
  int          exp_n;
  logic [63:0] got_a [0:7];
  logic [31:0] got_d [0:7];
  int          got_n;

  scatter_store_seq #(.VLEN(VLEN)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base_reg(cmd_base_reg), .cmd_gpr(cmd_gpr), .cmd_sp(cmd_sp),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .cmd_pred(cmd_pred),
    .cmd_lane64(cmd_lane64), .cmd_idx64(cmd_idx64),
    .cmd_idx_unsigned(cmd_idx_unsigned), .cmd_scale4(cmd_scale4),
    .cfg_check_empty(cfg_check_empty), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .align_fault(align_fault)
  );

  always #2 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++;
        bad++;
        $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] mk32(input logic [31:0] seed, input logic [31:0] step);
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = seed + 32'(i) * step;
    return v;
  endfunction

  function automatic logic [VLEN-1:0] mk64(input logic [63:0] seed, input logic [63:0] step);
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 64; i++) v[i*64 +: 64] = seed + 64'(i) * step;
    return v;
  endfunction

  // expected writes derived from the requirement text
  task automatic model(input bit fault);
    logic [63:0] base, ev, ext;
    int nl;
    exp_n = 0;
    if (fault) return;
    base = (cmd_base_reg == 5'd31) ? cmd_sp : cmd_gpr;
    nl = cmd_lane64 ? VLEN / 64 : VLEN / 32;
    for (int e = 0; e < nl; e++) begin
      if (cmd_lane64 ? cmd_pred[e*8] : cmd_pred[e*4]) begin
        if (cmd_lane64) begin
          ev = cmd_idx[e*64 +: 64];
          exp_d[exp_n] = cmd_data[e*64 +: 32];
        end else begin
          ev = {32'd0, cmd_idx[e*32 +: 32]};
          exp_d[exp_n] = cmd_data[e*32 +: 32];
        end
        if (cmd_idx64) ext = ev;
        else if (cmd_idx_unsigned) ext = {32'd0, ev[31:0]};
        else ext = {{32{ev[31]}}, ev[31:0]};
        exp_a[exp_n] = base + (cmd_scale4 ? (ext << 2) : ext);
        exp_n++;
      end
    end
  endtask

  // issues the command already placed on the cmd_* signals and checks the result
  task automatic run_cmd(input string req, input bit stall, input bit exp_fault);
    int n;
    bit seen_done, busy_ok;
    model(exp_fault);
    @(negedge clk);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    got_n = 0;
    seen_done = 1'b0;
    busy_ok = 1'b1;
    n = 0;
    while (!seen_done && n < 300) begin
      @(negedge clk);
      n++;
      if (done) begin
        seen_done = 1'b1;
        check(align_fault == exp_fault, req, "fault flag", 64'(align_fault), 64'(exp_fault));
      end else begin
        mem_ready = stall ? (n % 3 == 0) : 1'b1;
        if (mem_valid) begin
          if (cmd_ready) busy_ok = 1'b0;
          if (mem_ready && got_n < 8) begin
            got_a[got_n] = mem_addr;
            got_d[got_n] = mem_wdata;
            got_n++;
          end
        end
      end
    end
    mem_ready = 1'b0;
    check(seen_done, "R12", {req, " done seen"}, 64'(seen_done), 64'd1);
    check(busy_ok, "R1", {req, " ready low while busy"}, 64'(busy_ok), 64'd1);
    check(got_n == exp_n, req, "write count", 64'(got_n), 64'(exp_n));
    for (int i = 0; i < got_n && i < exp_n; i++) begin
      check(got_a[i] == exp_a[i], req, $sformatf("addr of write %0d", i), got_a[i], exp_a[i]);
      check(got_d[i] == exp_d[i], req, $sformatf("data of write %0d", i),
            64'(got_d[i]), 64'(exp_d[i]));
    end
    @(negedge clk);
    check(!done, "R12", {req, " done single cycle"}, 64'(done), 64'd0);
    check(cmd_ready, "R1", {req, " ready after done"}, 64'(cmd_ready), 64'd1);
  endtask

  task automatic set_cfg(input bit l64, input bit i64, input bit uns, input bit s4);
    cmd_lane64 = l64;
    cmd_idx64 = i64;
    cmd_idx_unsigned = uns;
    cmd_scale4 = s4;
  endtask

  task automatic t_reset;
    check(cmd_ready == 1'b1, "R1", "reset cmd_ready", 64'(cmd_ready), 64'd1);
    check(mem_valid == 1'b0, "R11", "reset mem_valid", 64'(mem_valid), 64'd0);
    check(done == 1'b0, "R12", "reset done", 64'(done), 64'd0);
    check(align_fault == 1'b0, "R9", "reset fault", 64'(align_fault), 64'd0);
  endtask

  task automatic t_signed32;  // R3 R4 R5 R7
    cmd_base_reg = 5'd3; cmd_gpr = 64'h0000_0000_0001_0000;
    cmd_idx = mk32(32'hFFFF_FFF0, 32'h0000_0011);
    cmd_data = mk32(32'hA000_0001, 32'h0101_0101);
    cmd_pred = '1;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1);
    run_cmd("R5 signed32 scaled", 1'b0, 1'b0);
  endtask

  task automatic t_unsigned_sparse;  // R2 R5
    cmd_base_reg = 5'd7; cmd_gpr = 64'h0000_0040_0000_0000;
    cmd_idx = mk32(32'h8000_0000, 32'h0000_0100);
    cmd_data = mk32(32'h1234_0000, 32'h0000_0003);
    cmd_pred = 32'h0E0F_F0F1;
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0);
    run_cmd("R2 sparse unsigned", 1'b0, 1'b0);
  endtask

  task automatic t_idx64_wrap;  // R4 R6 R7
    cmd_base_reg = 5'd0; cmd_gpr = 64'hFFFF_FFFF_FFFF_F000;
    cmd_idx = mk64(64'h8000_0000_0000_0800, 64'h0000_0001_0000_0800);
    cmd_data = mk64(64'hCAFE_0000_0000_0011, 64'h0001_0000_0000_0022);
    cmd_pred = '1;
    set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
    run_cmd("R6 idx64 wrap", 1'b0, 1'b0);
  endtask

  task automatic t_wide_signed;  // R2 R4 R5 R7
    cmd_base_reg = 5'd9; cmd_gpr = 64'h0000_0000_0000_2000;
    cmd_idx = mk64(64'hDEAD_BEEF_FFFF_FFF8, 64'h0000_0001_0000_0004);
    cmd_data = mk64(64'h7777_7777_0000_00AA, 64'h1111_1111_0000_0011);
    cmd_pred = 32'h0100_0011;
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1);
    run_cmd("R5 wide lanes signed idx", 1'b0, 1'b0);
  endtask

  task automatic t_sp_stall;  // R8 R11
    cmd_base_reg = 5'd31; cmd_sp = 64'h8000_0000_0000_0040;
    cmd_gpr = 64'h0000_0000_5555_0000;
    cmd_idx = mk32(32'h0000_0010, 32'h0000_0001);
    cmd_data = mk32(32'h0BAD_F00D, 32'h0000_1000);
    cmd_pred = 32'hF0F0_0F0F;
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1);
    cfg_check_empty = 1'b0;
    run_cmd("R8 sp base with stalls", 1'b1, 1'b0);
  endtask

  task automatic t_sp_fault;  // R9
    cmd_base_reg = 5'd31; cmd_sp = 64'h8000_0000_0000_0048;
    cmd_pred = 32'h0000_0010;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    run_cmd("R9 misaligned sp", 1'b0, 1'b1);
    cmd_base_reg = 5'd30; cmd_gpr = 64'h0000_0000_0000_0048;
    run_cmd("R9 misaligned gpr not checked", 1'b0, 1'b0);
  endtask

  task automatic t_empty;  // R10 R12
    cmd_base_reg = 5'd31; cmd_sp = 64'h0000_0000_0000_0004;
    cmd_pred = 32'hEEEE_EEEE;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    cfg_check_empty = 1'b1;
    run_cmd("R10 empty mask checked", 1'b0, 1'b1);
    cfg_check_empty = 1'b0;
    run_cmd("R10 empty mask unchecked", 1'b0, 1'b0);
    cmd_base_reg = 5'd1; cmd_pred = '0; cfg_check_empty = 1'b1;
    run_cmd("R12 empty mask gpr", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_signed32();
    t_unsigned_sparse();
    t_idx64_wrap();
    t_wide_signed();
    t_sp_stall();
    t_sp_fault();
    t_empty();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule